// File: doc/BRIEF.md
# Handshaked Parallel Port Controller

This block is a bidirectional parallel port with a per-bit direction register, reached through a small single-cycle register bus. It runs in one of four modes. In static mode the port is plain input/output. In strobed-input mode an external device latches pin data with an edge on the strobe input. In output-handshake mode the port tells the device when fresh output data is present and waits for an acknowledge edge. The three-state output variant adds an output enable taken from the strobe level. A clock-enable tick sets the pace of strobe sampling and of the ready-pulse timer.

There are two handshake lines. `strobeIn` is an edge-sensitive strobe/acknowledge input whose active edge can be selected. `readyOut` is an active-high ready output. An active strobe edge in a handshake mode sets a status flag, which can drive `irq`. Software clears the flag in two ordered steps: it reads the config register while the flag is set, then it reads or writes the latch address, depending on the mode.

Register addresses on `busAddr`: 0 = config/status, 1 = data port, 2 = latch (alternate data address), 3 = direction (1 = output). Config fields: bit 0 interrupt enable, bit 1 edge select, bit 2 pulse-ready select, bits 4:3 mode (00 static, 01 strobed input, 10 output handshake, 11 three-state output handshake), bit 7 status flag (read-only). Any other bit reads 0.

Top module: `pport_hsk`

## Requirements
- R1: After reset, every register reads 0, and `readyOut`, `irq`, `padOe` and `padOut` are all 0.
- R2: A write to address 1 or address 2 updates the same output register, which drives `padOut`. A read of address 1 returns `padIn` on bits whose direction bit is 0 and the output register on bits whose direction bit is 1.
- R3: With edge select 0 the strobe is asserted high and its falling edge is the active edge. With edge select 1 it is asserted low and its rising edge is the active edge. The inactive edge has no effect.
- R4: In strobed-input mode an active strobe edge copies `padIn` into the latch (read at address 2) and sets the status flag.
- R5: When a config write moves the block into strobed-input mode, `readyOut` stays 0 until the first read of address 2.
- R6: In strobed-input mode with pulse select 0, a read of address 2 raises `readyOut`, and it stays high until the next active strobe edge.
- R7: In strobed-input mode with pulse select 1, a read of address 2 raises `readyOut` for exactly two tick periods. The flag is still set by active edges.
- R8: In strobed-input mode, a read of address 2 clears the flag only if a config read has seen the flag set since the flag was last cleared. Without that config read, the flag stays set.
- R9: In both output-handshake modes, a write to address 1 or 2 raises `readyOut`. An active strobe edge drops `readyOut` and sets the flag. After a config read that sees the flag set, a write to address 2 clears the flag, while a write to address 1 does not.
- R10: In three-state mode, while the strobe is negated `padOe` equals the direction register. While the strobe is asserted, `padOe` is all ones.
- R11: `irq` is 1 exactly when the status flag and the interrupt enable are both set.
- R12: In static mode `readyOut` stays 0 and strobe edges do not set the flag.
- R13: In strobed-input mode, writes to address 1 or 2 change `padOut` but leave `readyOut` as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable for strobe sampling and the pulse timer |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| padIn | input | 8 | Pin levels |
| padOut | output | 8 | Output register to the pin drivers |
| padOe | output | 8 | Per-bit pin drive enable |
| strobeIn | input | 1 | Strobe / acknowledge input |
| readyOut | output | 1 | Ready output |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the ordered flag clear. It reads the latch while the flag is set but before any config read, and it writes the data address after the config read. A design that cleared the flag on any latch access would drop `irq` in the first case, and one that cleared on either address would drop it in the second. It also enters strobed-input mode and checks that ready stays low until the dummy read; a design that raised ready on mode entry would let the device strobe too early. It runs the pulse mode with a slow tick and counts tick periods, which catches a pulse timed in clocks or off by one. It also drives the inactive strobe edge under both edge settings, which catches inverted edge selection.

// File: rtl/pport_pkg.sv
package pport_pkg;

  localparam logic [1:0] ADDR_CFG   = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_LATCH = 2'd2;
  localparam logic [1:0] ADDR_DIR   = 2'd3;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'b00,
    MODE_IN     = 2'b01,
    MODE_OUT    = 2'b10,
    MODE_OUT3   = 2'b11
  } mode_e;

  typedef struct packed {
    logic capture;
    logic wrOut;
    logic wrDir;
    logic driveAll;
  } strobes_t;

endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [4:0]       cfgWdata,
  input  logic             strobeIn,
  output strobes_t         strb,
  output logic [WIDTH-1:0] cfgView,
  output mode_e            modeNow,
  output logic             readyOut,
  output logic             irq
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // strobe synchronizer plus one extra stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else if (tick) syncQ <= {syncQ[SYNC_STAGES-1:0], strobeIn};
  end

  logic syncNow, syncPrev;
  assign syncNow  = syncQ[SYNC_STAGES-1];
  assign syncPrev = syncQ[SYNC_STAGES];

  // config and handshake state
  logic irqEn, edgeSel, pulseSel;
  mode_e mode;
  logic ready, flag, armed;
  logic [CNT_W-1:0] cnt;

  logic irqEnN, edgeSelN, pulseSelN;
  mode_e modeN;
  logic readyN, flagN, armedN;
  logic [CNT_W-1:0] cntN;

  logic cfgWr, cfgRd, datWr, latWr, latRd, dirWr;
  logic activeEdge, strobeAsserted;
  logic setFlag, clrFlag;

  assign cfgWr = busSel &  busWr & (busAddr == ADDR_CFG);
  assign cfgRd = busSel & ~busWr & (busAddr == ADDR_CFG);
  assign datWr = busSel &  busWr & (busAddr == ADDR_DATA);
  assign latWr = busSel &  busWr & (busAddr == ADDR_LATCH);
  assign latRd = busSel & ~busWr & (busAddr == ADDR_LATCH);
  assign dirWr = busSel &  busWr & (busAddr == ADDR_DIR);

  assign activeEdge     = tick & (edgeSel ? (syncNow & ~syncPrev) : (~syncNow & syncPrev));
  assign strobeAsserted = edgeSel ? ~syncNow : syncNow;

  always_comb begin
    irqEnN    = irqEn;
    edgeSelN  = edgeSel;
    pulseSelN = pulseSel;
    modeN     = mode;
    readyN    = ready;
    cntN      = cnt;
    flagN     = flag;
    armedN    = armed;
    setFlag   = 1'b0;
    clrFlag   = 1'b0;
    if (cfgWr) begin
      irqEnN    = cfgWdata[0];
      edgeSelN  = cfgWdata[1];
      pulseSelN = cfgWdata[2];
      modeN     = mode_e'(cfgWdata[4:3]);
      if (modeN != mode) begin
        readyN = 1'b0;
        cntN   = '0;
        flagN  = 1'b0;
        armedN = 1'b0;
      end
    end else begin
      if (cfgRd && flag) armedN = 1'b1;
      case (mode)
        MODE_IN: begin
          if (pulseSel && ready && tick && (cnt != '0)) begin
            cntN = cnt - CNT_ONE;
            if (cnt == CNT_ONE) readyN = 1'b0;
          end
          if (activeEdge) begin
            setFlag = 1'b1;
            if (!pulseSel) readyN = 1'b0;
          end
          if (latRd) begin
            readyN = 1'b1;
            cntN   = pulseSel ? PULSE_LOAD : '0;
            if (armed && flag) clrFlag = 1'b1;
          end
        end
        MODE_OUT, MODE_OUT3: begin
          if (activeEdge) begin
            readyN  = 1'b0;
            setFlag = 1'b1;
          end
          if (datWr || latWr) readyN = 1'b1;
          if (latWr && armed && flag) clrFlag = 1'b1;
        end
        default: begin
          readyN = 1'b0;
          cntN   = '0;
        end
      endcase
      if (clrFlag) begin
        flagN  = 1'b0;
        armedN = 1'b0;
      end
      if (setFlag) flagN = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      edgeSel  <= 1'b0;
      pulseSel <= 1'b0;
      mode     <= MODE_STATIC;
      ready    <= 1'b0;
      cnt      <= '0;
      flag     <= 1'b0;
      armed    <= 1'b0;
    end else begin
      irqEn    <= irqEnN;
      edgeSel  <= edgeSelN;
      pulseSel <= pulseSelN;
      mode     <= modeN;
      ready    <= readyN;
      cnt      <= cntN;
      flag     <= flagN;
      armed    <= armedN;
    end
  end

  always_comb begin
    cfgView          = '0;
    cfgView[0]       = irqEn;
    cfgView[1]       = edgeSel;
    cfgView[2]       = pulseSel;
    cfgView[4:3]     = mode;
    cfgView[WIDTH-1] = flag;
  end

  assign strb.capture  = (mode == MODE_IN) & activeEdge;
  assign strb.wrOut    = datWr | latWr;
  assign strb.wrDir    = dirWr;
  assign strb.driveAll = (mode == MODE_OUT3) & strobeAsserted;

  assign modeNow  = mode;
  assign readyOut = ready;
  assign irq      = flag & irqEn;

endmodule

// File: rtl/pport_dpath.sv
module pport_dpath
  import pport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] padIn,
  input  logic [WIDTH-1:0] cfgView,
  output logic [WIDTH-1:0] busRdata,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe
);
  logic [WIDTH-1:0] outReg, dirReg, latchReg, portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '0;
      latchReg <= '0;
    end else begin
      if (strb.wrOut)   outReg   <= busWdata;
      if (strb.wrDir)   dirReg   <= busWdata;
      if (strb.capture) latchReg <= padIn;
    end
  end

  // per-bit view of the port: pin level for inputs, driver input for outputs
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign portView[b] = dirReg[b] ? outReg[b] : padIn[b];
    assign padOe[b]    = strb.driveAll | dirReg[b];
  end

  always_comb begin
    case (busAddr)
      ADDR_CFG:   busRdata = cfgView;
      ADDR_DATA:  busRdata = portView;
      ADDR_LATCH: busRdata = latchReg;
      default:    busRdata = dirReg;
    endcase
  end

  assign padOut = outReg;

endmodule

// File: rtl/pport_hsk.sv
module pport_hsk
  import pport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  input  logic             strobeIn,
  output logic             readyOut,
  output logic             irq
);
  strobes_t         strb;
  logic [WIDTH-1:0] cfgView;
  mode_e            modeNow;

  pport_ctrl #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .PULSE_TICKS(PULSE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .cfgWdata(busWdata[4:0]), .strobeIn(strobeIn),
    .strb(strb), .cfgView(cfgView), .modeNow(modeNow),
    .readyOut(readyOut), .irq(irq)
  );

  pport_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busAddr(busAddr), .busWdata(busWdata), .padIn(padIn),
    .cfgView(cfgView), .busRdata(busRdata),
    .padOut(padOut), .padOe(padOe)
  );

endmodule

// File: rtl/pport_sva.sv
module pport_sva
  import pport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWr,
  input logic [1:0]       busAddr,
  input logic [WIDTH-1:0] busWdata,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic             readyOut,
  input mode_e            modeNow
);
  logic cfgWr, outWr, dirWr, latRd;
  assign cfgWr = busSel &  busWr & (busAddr == ADDR_CFG);
  assign outWr = busSel &  busWr & ((busAddr == ADDR_DATA) | (busAddr == ADDR_LATCH));
  assign dirWr = busSel &  busWr & (busAddr == ADDR_DIR);
  assign latRd = busSel & ~busWr & (busAddr == ADDR_LATCH);

  assert_static_noready_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_STATIC) |-> !readyOut);

  assert_entry_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && busWdata[4:3] == MODE_IN && modeNow != MODE_IN) |=> !readyOut);

  assert_latch_read_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_IN && latRd) |=> readyOut);

  assert_out_write_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((modeNow == MODE_OUT || modeNow == MODE_OUT3) && outWr) |=> readyOut);

  assert_oe_steady_R10: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow != MODE_OUT3 && !dirWr && !cfgWr) |=> $stable(padOe));

  assert_out_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!outWr) |=> $stable(padOut));

endmodule

bind pport_hsk pport_sva #(.WIDTH(WIDTH)) u_sva (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .padOut(padOut),
  .padOe(padOe), .readyOut(readyOut), .modeNow(modeNow)
);

// File: tb/sim_pport_hsk.sv
`timescale 1ns/1ps
module sim_pport_hsk;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic [7:0] padIn = 8'd0;
  logic [7:0] padOut, padOe;
  logic       strobeIn = 1'b0;
  logic       readyOut, irq;

  int nChecks = 0, nFails = 0;
  int tickDiv = 1;
  bit finished = 0;

  always #4 clk = ~clk;

  pport_hsk u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .strobeIn(strobeIn), .readyOut(readyOut), .irq(irq)
  );

  initial begin
    int ph;
    ph = 0;
    tick = 1'b1;
    forever begin
      @(negedge clk);
      if (tickDiv <= 1) tick = 1'b1;
      else begin
        ph = (ph + 1) % tickDiv;
        tick = (ph == 0);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic setStrobe(input logic v);
    @(negedge clk);
    strobeIn = v;
    repeat (8) @(negedge clk);
  endtask

  task automatic settle();
    busWrite(2'd0, 8'h00);
    setStrobe(1'b0);
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R1 readyOut", readyOut, 0);
    check("R1 irq", irq, 0);
    check("R1 padOe", padOe, 0);
    check("R1 padOut", padOut, 0);
    for (int a = 0; a < 4; a++) begin
      busRead(a[1:0], d);
      check("R1 register readback", d, 0);
    end
  endtask

  task automatic testStatic();
    logic [7:0] d;
    busWrite(2'd3, 8'hF0);
    padIn = 8'h5A;
    busWrite(2'd1, 8'h3C);
    check("R2 padOut after data write", padOut, 8'h3C);
    busRead(2'd1, d);
    check("R2 data read mixes pins and outputs", d, 8'h3A);
    busWrite(2'd2, 8'h81);
    check("R2 latch-address write hits output register", padOut, 8'h81);
    check("R10 padOe follows dir outside three-state", padOe, 8'hF0);
    busWrite(2'd0, 8'h01);
    setStrobe(1'b1);
    setStrobe(1'b0);
    check("R12 static mode ignores strobe flag", irq, 0);
    check("R12 static mode ready low", readyOut, 0);
    settle();
  endtask

  task automatic testInputInterlock();
    logic [7:0] d;
    busWrite(2'd3, 8'h00);
    busWrite(2'd0, 8'h09);
    check("R5 ready low after entering input mode", readyOut, 0);
    padIn = 8'hC3;
    setStrobe(1'b1);
    setStrobe(1'b0);
    check("R4 flag set by active edge (irq, R11)", irq, 1);
    busRead(2'd2, d);
    check("R4 latch holds pins", d, 8'hC3);
    check("R8 latch read without config read keeps flag", irq, 1);
    check("R6 ready high after latch read", readyOut, 1);
    busWrite(2'd1, 8'h77);
    check("R13 data write keeps ready", readyOut, 1);
    check("R13 data write reaches padOut", padOut, 8'h77);
    busRead(2'd0, d);
    check("R8 config read shows flag at bit 7", d[7], 1);
    busRead(2'd2, d);
    check("R8 ordered access clears flag", irq, 0);
    repeat (10) @(negedge clk);
    check("R6 interlock ready holds without edge", readyOut, 1);
    padIn = 8'h1E;
    setStrobe(1'b1);
    check("R3 rising edge inactive with select 0", irq, 0);
    check("R6 ready held through inactive edge", readyOut, 1);
    setStrobe(1'b0);
    check("R6 ready dropped by active edge", readyOut, 0);
    busRead(2'd2, d);
    check("R4 second capture", d, 8'h1E);
    settle();
  endtask

  task automatic testEdgeSel();
    logic [7:0] d;
    setStrobe(1'b1);
    busWrite(2'd0, 8'h0B);
    padIn = 8'h66;
    setStrobe(1'b0);
    check("R3 falling edge inactive with select 1", irq, 0);
    setStrobe(1'b1);
    check("R3 rising edge active with select 1", irq, 1);
    busRead(2'd2, d);
    check("R3 capture on rising edge", d, 8'h66);
    settle();
  endtask

  task automatic testPulse();
    int cnt;
    logic [7:0] d;
    busWrite(2'd0, 8'h0D);
    check("R5 ready low on pulse-mode entry", readyOut, 0);
    tickDiv = 3;
    busRead(2'd2, d);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      #1;
      if (!readyOut) break;
      if (tick) cnt++;
      @(negedge clk);
    end
    check("R7 ready pulse length in ticks", cnt, 2);
    check("R7 ready low after pulse", readyOut, 0);
    tickDiv = 1;
    setStrobe(1'b1);
    setStrobe(1'b0);
    check("R7 flag still set in pulse mode", irq, 1);
    settle();
  endtask

  task automatic testOutput();
    logic [7:0] d;
    busWrite(2'd3, 8'hFF);
    busWrite(2'd0, 8'h11);
    check("R9 ready low on output-mode entry", readyOut, 0);
    busWrite(2'd1, 8'hA5);
    check("R9 data write raises ready", readyOut, 1);
    setStrobe(1'b1);
    setStrobe(1'b0);
    check("R9 ack edge drops ready", readyOut, 0);
    check("R9 ack edge sets flag", irq, 1);
    busRead(2'd0, d);
    busWrite(2'd1, 8'h5A);
    check("R9 data-address write keeps flag", irq, 1);
    check("R9 data write raises ready again", readyOut, 1);
    busWrite(2'd2, 8'h3C);
    check("R9 latch write after config read clears flag", irq, 0);
    check("R9 latch write updates padOut", padOut, 8'h3C);
    settle();
  endtask

  task automatic testThreeState();
    busWrite(2'd3, 8'h0F);
    busWrite(2'd0, 8'h18);
    repeat (2) @(negedge clk);
    check("R10 negated strobe: padOe = dir", padOe, 8'h0F);
    setStrobe(1'b1);
    check("R10 asserted strobe: all bits drive", padOe, 8'hFF);
    check("R11 irq masked with enable 0", irq, 0);
    setStrobe(1'b0);
    check("R10 padOe back to dir", padOe, 8'h0F);
    busWrite(2'd0, 8'h19);
    check("R11 flag exposed when enable set", irq, 1);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testStatic();
    testInputInterlock();
    testEdgeSel();
    testPulse();
    testOutput();
    testThreeState();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule